// File: doc/BRIEF.md
# Fractional saturating multiplier

This unit multiplies two signed fixed-point fractions of one selectable element width: 8, 16, 32 or 64 bits. It sign-extends both operands from the chosen width and forms their full product. The product is doubled, so that two Q-format fractions give a fraction in the same format. It then keeps the upper element-width bits and rounds them under one of four modes. Any value that does not fit the signed range of the element is clamped, and a saturation flag is raised.

The unit is a two-stage pipeline with a fixed latency. A new operand pair can be accepted every cycle. The first stage sign-extends the operands and multiplies them. The second stage rounds, clamps and masks the result. The result and the saturation flag appear together, qualified by an output valid strobe, two clock edges after the input valid was sampled.

Top module: `fracmul_sat`

## Requirements
- R1: `width_sel` picks the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Each operand is taken from its low element-width bits and sign-extended. Operand bits above the element width have no effect on the result.
- R2: When no saturation occurs, the result is the product of the two signed operands multiplied by two, arithmetically shifted right by the element width (a floor), plus the rounding increment.
- R3: In rounding mode 0 (nearest, ties up), the increment is the bit just below the kept part.
- R4: In rounding mode 1 (nearest, ties to even), the increment is that bit ANDed with the OR of two terms. The first term is any lower discarded bit. The second term is the kept LSB.
- R5: In rounding mode 2 (toward negative infinity), the increment is always 0.
- R6: In rounding mode 3 (round to odd), the increment is 1 only when the kept LSB is 0 and any discarded bit is 1.
- R7: When both operands equal the most negative value of the element, the result is the most positive value and `sat` is 1, whatever the rounding mode.
- R8: A rounded value above the element's signed maximum gives that maximum, and a value below the minimum gives that minimum. Both cases set `sat`. Otherwise `sat` is 0.
- R9: Result bits at and above the element width are 0.
- R10: `out_valid` is asserted exactly two rising edges after `in_valid` is sampled high. Each accepted pair gives exactly one result, and back-to-back inputs give back-to-back results.
- R11: During reset, `out_valid`, `result` and `sat` are 0. `sat` is 0 in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is presented this cycle |
| op_a | input | W (64) | Multiplicand, element in the low bits |
| op_b | input | W (64) | Multiplier, element in the low bits |
| width_sel | input | 2 | Element width code (R1) |
| rnd_mode | input | 2 | Rounding mode code (R3 to R6) |
| out_valid | output | 1 | Result and flag are valid |
| result | output | W (64) | Rounded, clamped product, zero-extended |
| sat | output | 1 | Result was clamped |

## Verification
The bound checker watches the pipeline timing on every cycle. It also checks the minimum-times-minimum outcome, the zeroed bits above the element width, the rule that a raised flag leaves only an end-of-range value on the result, and the quiet flag between results. The numeric correctness of the rounding modes can only be shown by the bench's scenarios. The bench uses hand-computed tie, above-tie and below-tie cases at 8 bits, and an independent model of products at every width and mode, including minimum times one and operands with junk upper bits.

// File: rtl/fracmul_sat.sv
module fracmul_sat #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   width_sel,
  input  logic [1:0]   rnd_mode,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         sat
);
  localparam int PW = 2 * W;
  localparam int SW = $clog2(W) + 1;

  logic [SW-1:0] ew_in, pad_in;
  logic [W-1:0]  sa, sb, minv_in;
  logic          both_min;

  assign ew_in    = SW'(8) << width_sel;
  assign pad_in   = SW'(W) - ew_in;
  assign sa       = W'($signed(op_a << pad_in) >>> pad_in);
  assign sb       = W'($signed(op_b << pad_in) >>> pad_in);
  assign minv_in  = {W{1'b1}} << (ew_in - SW'(1));
  assign both_min = (sa == minv_in) && (sb == minv_in);

  logic                 v1, mm1;
  logic signed [PW-1:0] prod1;
  logic [SW-1:0]        ew1;
  logic [1:0]           md1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      mm1   <= 1'b0;
      prod1 <= '0;
      ew1   <= SW'(8);
      md1   <= 2'd0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        prod1 <= PW'($signed(sa)) * PW'($signed(sb));
        mm1   <= both_min;
        ew1   <= ew_in;
        md1   <= rnd_mode;
      end
    end
  end

  logic signed [PW:0] dbl, trunc, rnd, hi, lo;
  logic [PW:0]        lowmask;
  logic [SW-1:0]      ewm1;
  logic [W-1:0]       emask, res_c;
  logic               lsb, guard, sticky, inc, ovf, unf;

  assign dbl     = $signed({prod1, 1'b0});
  assign ewm1    = ew1 - SW'(1);
  assign trunc   = dbl >>> ew1;
  assign lsb     = dbl[ew1];
  assign guard   = dbl[ewm1];
  assign lowmask = ~({(PW+1){1'b1}} << ewm1);
  assign sticky  = |(dbl & lowmask);

  always_comb begin
    case (md1)
      2'd0:    inc = guard;
      2'd1:    inc = guard & (sticky | lsb);
      2'd2:    inc = 1'b0;
      default: inc = ~lsb & (guard | sticky);
    endcase
  end

  assign rnd   = trunc + (PW+1)'(inc);
  assign hi    = $signed(lowmask);
  assign lo    = ~hi;
  assign ovf   = mm1 | (rnd > hi);
  assign unf   = ~mm1 & (rnd < lo);
  assign emask = {W{1'b1}} >> (SW'(W) - ew1);
  assign res_c = (ovf ? W'(hi) : unf ? W'(lo) : W'(rnd)) & emask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat       <= 1'b0;
    end else begin
      out_valid <= v1;
      sat       <= v1 & (ovf | unf);
      if (v1) result <= res_c;
    end
  end
endmodule

// File: rtl/fracmul_sat_chk.sv
module fracmul_sat_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [1:0]   width_sel,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         sat
);
  localparam int SW = $clog2(W) + 1;
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

  logic [SW-1:0] ew_now, ew_o;
  logic          a_min, b_min;
  logic [1:0]    vq, mmq;
  logic [1:0]    wq0, wq1;
  logic [W-1:0]  maxpat, minpat;

  assign ew_now = SW'(8) << width_sel;
  assign a_min  = (op_a << (SW'(W) - ew_now)) == TOP;
  assign b_min  = (op_b << (SW'(W) - ew_now)) == TOP;
  assign ew_o   = SW'(8) << wq1;
  assign maxpat = {W{1'b1}} >> (SW'(W) - ew_o + SW'(1));
  assign minpat = W'(1) << (ew_o - SW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq  <= '0;
      mmq <= '0;
      wq0 <= '0;
      wq1 <= '0;
    end else begin
      vq  <= {vq[0], in_valid};
      mmq <= {mmq[0], in_valid & a_min & b_min};
      wq0 <= width_sel;
      wq1 <= wq0;
    end
  end

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vq[1]);
  p_min_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vq[1] && mmq[1]) |-> (sat && result == maxpat));
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((result >> ew_o) == '0));
  p_clamp_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sat) |-> (result == maxpat || result == minpat));
  p_flag_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !sat);
endmodule

bind fracmul_sat fracmul_sat_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .width_sel(width_sel), .out_valid(out_valid), .result(result), .sat(sat)
);

// File: tb/fracmul_sat_tb.sv
`timescale 1ns/1ps
module fracmul_sat_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  width_sel = '0, rnd_mode = '0;
  logic        out_valid, sat;
  logic [63:0] result;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [63:0] res; logic s; string tag; } exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;

  fracmul_sat #(.W(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .width_sel(width_sel), .rnd_mode(rnd_mode), .out_valid(out_valid),
    .result(result), .sat(sat)
  );

  function automatic logic [64:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input int w, input int md);
    logic signed [63:0]  sa, sb;
    logic signed [129:0] d, q, rem, half, r, mx, mn;
    logic [63:0]         m;
    logic                inc, s;
    sa = $signed(a << (64 - w)) >>> (64 - w);
    sb = $signed(b << (64 - w)) >>> (64 - w);
    mx = (130'sd1 <<< (w - 1)) - 130'sd1;
    mn = -mx - 130'sd1;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    if (sa == 64'(mn) && sb == 64'(mn)) return {1'b1, 64'(mx) & m};
    d    = (130'(sa) * 130'(sb)) <<< 1;
    q    = d >>> w;
    rem  = d - (q <<< w);
    half = 130'sd1 <<< (w - 1);
    case (md)
      0:       inc = rem >= half;
      1:       inc = (rem > half) || (rem == half && q[0]);
      2:       inc = 1'b0;
      default: inc = (rem != 0) && !q[0];
    endcase
    r = q + 130'(inc);
    s = 1'b0;
    if (r > mx) begin r = mx; s = 1'b1; end
    else if (r < mn) begin r = mn; s = 1'b1; end
    return {s, 64'(r) & m};
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input int ws,
                       input int md, input logic [63:0] er, input logic es, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid  = 1'b1;
    op_a      = a;
    op_b      = b;
    width_sel = 2'(ws);
    rnd_mode  = 2'(md);
    e.res = er; e.s = es; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic send(input logic [63:0] a, input logic [63:0] b, input int ws,
                      input int md, input string tag);
    logic [64:0] x;
    x = model(a, b, 8 << ws, md);
    drive(a, b, ws, md, x[63:0], x[64], tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = {$urandom, $urandom};
      op_b = {$urandom, $urandom};
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        n_vec++;
        if (sbq.size() == 0) begin
          n_bad++;
          $display("FAIL R10 unexpected result: actual %h expected no output", result);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          if (result !== e.res || sat !== e.s) begin
            n_bad++;
            $display("FAIL %s: actual res=%h sat=%b expected res=%h sat=%b",
                     e.tag, result, sat, e.res, e.s);
          end
        end
      end else if (sat !== 1'b0) begin
        n_vec++;
        n_bad++;
        $display("FAIL R11 flag without valid: actual %b expected 0", sat);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || result !== '0 || sat !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset state: actual v=%b r=%h s=%b expected 0 0 0",
               out_valid, result, sat);
    end
    rst_n = 1'b1;

    // R3 R4 R5 R6: hand-computed 8-bit rounding (ws=0)
    drive(64'h01, 64'h40, 0, 0, 64'h01, 0, "R3 tie");
    drive(64'h01, 64'h40, 0, 1, 64'h00, 0, "R4 tie even");
    drive(64'h01, 64'h40, 0, 2, 64'h00, 0, "R5 tie");
    drive(64'h01, 64'h40, 0, 3, 64'h01, 0, "R6 tie");
    drive(64'h03, 64'h40, 0, 0, 64'h02, 0, "R3 odd tie");
    drive(64'h03, 64'h40, 0, 1, 64'h02, 0, "R4 odd tie");
    drive(64'h03, 64'h40, 0, 2, 64'h01, 0, "R5 odd tie");
    drive(64'h03, 64'h40, 0, 3, 64'h01, 0, "R6 odd tie");
    drive(64'hFF, 64'h40, 0, 0, 64'h00, 0, "R3 negative tie");
    drive(64'hFF, 64'h40, 0, 1, 64'h00, 0, "R4 negative tie");
    drive(64'hFF, 64'h40, 0, 2, 64'hFF, 0, "R5 negative tie");
    drive(64'hFF, 64'h40, 0, 3, 64'hFF, 0, "R6 negative tie");
    drive(64'h01, 64'h41, 0, 1, 64'h01, 0, "R4 above tie");
    drive(64'h01, 64'h20, 0, 0, 64'h00, 0, "R3 below tie");
    drive(64'h01, 64'h20, 0, 3, 64'h01, 0, "R6 below tie");
    drive(64'hABCD_0000_0000_0003, 64'h1234_0000_0000_0040, 0, 2, 64'h01, 0, "R1 junk upper");
    idle(4);

    for (int ws = 0; ws < 4; ws++) begin
      for (int md = 0; md < 4; md++) begin
        int w;
        logic [63:0] mn, mx, junk;
        w    = 8 << ws;
        mn   = 64'd1 << (w - 1);
        mx   = mn - 64'd1;
        junk = (w == 64) ? '0 : ({$urandom, $urandom} << w);
        send(mn | junk, mn, ws, md, "R7 min*min");
        send(mn, 64'd1 | junk, ws, md, "R2 R9 min*one");
        send(mn, mx, ws, md, "R2 R8 min*max");
        send(mx, mx | junk, ws, md, "R2 max*max");
        for (int k = 0; k < 4; k++)
          send({$urandom, $urandom}, {$urandom, $urandom}, ws, md, "R1 R2 R8 R9 random");
      end
      idle(ws + 1);
    end

    for (int k = 0; k < 200; k++)
      send({$urandom, $urandom}, {$urandom, $urandom}, k % 4, (k / 4) % 4, "R10 burst");
    idle(6);

    n_vec++;
    if (sbq.size() != 0) begin
      n_bad++;
      $display("FAIL R10 missing results: actual %0d pending expected 0", sbq.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule